// File: doc/BRIEF.md
# Sector Load and Program Controller

This block is a clocked behavioural model of the write engine in a byte-wide nonvolatile memory that is written one whole sector at a time. All bus pins are sampled on the system clock: an address bus, an input data bus, an output data bus with an output-valid flag, and three active-low controls for chip select, read enable and write strobe. A write strobe happens when chip select and write strobe are both low while read enable is high. Each strobe places one byte into a 256-byte staging buffer that belongs to the sector named by the first byte.

The load window stays open while each new strobe starts soon enough after the previous one ends. When no new strobe starts in time, the window closes. The controller then erases the target sector to FFh and writes the staged bytes into it, all under an internal cycle counter. While this cycle runs, a read does not return array data. It returns a status byte. Bit 7 of that byte is the inverse of bit 7 of the last loaded byte, and bit 6 changes value after each completed read. The array is a small register store whose size is set by a parameter. The window length and the cycle length are counted in clocks.

Top module: `slp_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and every array byte reads FFh.
- R2: When `cs_n`=0, `rd_n`=0 and `wr_n`=1 and no cycle is running, `dout_en`=1 and `dout` shows the array byte at `addr`. When `cs_n` or `rd_n` is 1, `dout_en`=0.
- R3: A write strobe lasts while `cs_n`=0, `wr_n`=0 and `rd_n`=1. The byte address is taken at the first clock of the strobe. The data is the value of `din` at the last clock of the strobe. `addr` bits 7:0 select the byte, and the bits above them select the sector.
- R4: After a byte is accepted at clock edge E, a strobe first sampled at or before edge E+LOAD_TO is accepted. If no strobe has been seen by edge E+LOAD_TO, `busy` rises at that edge. When a strobe arrives at that same edge, the strobe takes priority.
- R5: A cycle keeps `busy` high for exactly PROG_CYC clocks. Afterwards, the sector holds every loaded byte, in whatever order the bytes were loaded, and every byte that was not loaded reads FFh.
- R6: While `busy` is 1, a read returns a status byte. In it, bit 7 is the inverse of bit 7 of the last accepted byte, and bits 5:0 equal bits 5:0 of that byte.
- R7: Bit 6 of the status byte is 0 on the first read of a cycle and inverts after each completed read. Once `busy` falls, reads return true array data.
- R8: Within a window, a strobe whose sector differs from the first byte's sector has no effect.
- R9: A strobe attempted while `rd_n`=0, or while `cs_n`=1, writes nothing and starts no cycle.
- R10: Strobes made while `busy` is 1 are ignored.
- R11: A cycle changes only its own sector. Other sectors keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | SECTOR_BITS+8 | Byte address (sector, byte) |
| din | input | 8 | Write data |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | Output bus driven |
| busy | output | 1 | Erase/write cycle running |

## Verification
Two events can land on the same clock edge: the window timing out, and the start of a new strobe. The bench provokes this by placing the next strobe exactly LOAD_TO edges after the previous byte was accepted. The strobe must win: that byte must be present after programming, and `busy` must rise exactly LOAD_TO edges after that byte is accepted. A gap one clock longer must instead start the cycle, and the late byte must be dropped.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int SEC_BYTES = 256;
  localparam int BYTE_AW   = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_ERASE = 2'd2,
    ST_PROG  = 2'd3
  } slp_state_e;
endpackage

// File: rtl/slp_strobe.sv
module slp_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_act,
  output logic wr_start,
  output logic wr_end,
  output logic rd_act,
  output logic rd_end
);
  logic wr_q, rd_q;

  assign wr_act   = ~cs_n & ~wr_n & rd_n;
  assign rd_act   = ~cs_n & ~rd_n & wr_n;
  assign wr_start = wr_act & ~wr_q;
  assign wr_end   = ~wr_act & wr_q;
  assign rd_end   = ~rd_act & rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int SECTOR_BITS = 2,
  parameter int LOAD_TO     = 15000,
  parameter int PROG_CYC    = 1000000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_act,
  input  logic                   wr_start,
  input  logic                   wr_end,
  input  logic                   rd_end,
  input  logic [SECTOR_BITS-1:0] in_sec,
  input  logic [BYTE_AW-1:0]     in_byte,
  input  logic [7:0]             din,
  output logic                   commit,
  output logic [BYTE_AW-1:0]     cm_byte,
  output logic [7:0]             cm_data,
  output logic                   clr_buf,
  output logic                   erase_en,
  output logic                   prog_en,
  output logic [SECTOR_BITS-1:0] sec,
  output logic                   busy,
  output logic                   tog,
  output logic [7:0]             status
);
  localparam int CMAX = (LOAD_TO > PROG_CYC) ? LOAD_TO : PROG_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] LT_END = CW'(LOAD_TO - 1);
  localparam logic [CW-1:0] PC_END = CW'(PROG_CYC - 2);

  slp_state_e             st_q, st_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic [SECTOR_BITS-1:0] sec_q, sec_d;
  logic [BYTE_AW-1:0]     byte_q, byte_d;
  logic                   stb_q, stb_d;
  logic                   tog_q, tog_d;
  logic [6:0]             last_q, last_d;
  logic [7:0]             data_q;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sec_d    = sec_q;
    byte_d   = byte_q;
    stb_d    = stb_q;
    tog_d    = tog_q;
    last_d   = last_q;
    commit   = 1'b0;
    clr_buf  = 1'b0;
    erase_en = 1'b0;
    prog_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wr_start) begin
          st_d    = ST_LOAD;
          sec_d   = in_sec;
          byte_d  = in_byte;
          stb_d   = 1'b1;
          clr_buf = 1'b1;
        end
      end
      ST_LOAD: begin
        if (wr_start && (in_sec == sec_q)) begin
          byte_d = in_byte;
          stb_d  = 1'b1;
        end else if (wr_end && stb_q) begin
          commit = 1'b1;
          stb_d  = 1'b0;
          cnt_d  = '0;
          last_d = {data_q[7], data_q[5:0]};
        end else if (!stb_q) begin
          if (cnt_q == LT_END) begin
            st_d  = ST_ERASE;
            tog_d = 1'b0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_ERASE: begin
        erase_en = 1'b1;
        cnt_d    = '0;
        st_d     = ST_PROG;
        if (rd_end) tog_d = ~tog_q;
      end
      ST_PROG: begin
        if (rd_end) tog_d = ~tog_q;
        if (cnt_q == PC_END) begin
          prog_en = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sec_q  <= '0;
      byte_q <= '0;
      stb_q  <= 1'b0;
      tog_q  <= 1'b0;
      last_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sec_q  <= sec_d;
      byte_q <= byte_d;
      stb_q  <= stb_d;
      tog_q  <= tog_d;
      last_q <= last_d;
      if (wr_act) data_q <= din;
    end
  end

  assign cm_byte = byte_q;
  assign cm_data = data_q;
  assign sec     = sec_q;
  assign busy    = (st_q == ST_ERASE) || (st_q == ST_PROG);
  assign tog     = tog_q;
  assign status  = {~last_q[6], tog_q, last_q[5:0]};
endmodule

// File: rtl/slp_buffer.sv
module slp_buffer
  import slp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [BYTE_AW-1:0]     wr_idx,
  input  logic [7:0]             wr_data,
  output logic [SEC_BYTES*8-1:0] bytes_o,
  output logic [SEC_BYTES-1:0]   mask_o
);
  logic [7:0]           data_q [SEC_BYTES];
  logic [SEC_BYTES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (clr) begin
      mask_q <= '0;
    end else if (wr_en) begin
      mask_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < SEC_BYTES; g++) begin : g_flat
    assign bytes_o[g*8 +: 8] = data_q[g];
  end
  assign mask_o = mask_q;
endmodule

// File: rtl/slp_array.sv
module slp_array
  import slp_pkg::*;
#(
  parameter int SECTOR_BITS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   erase_en,
  input  logic                   prog_en,
  input  logic [SECTOR_BITS-1:0] wsec,
  input  logic [SEC_BYTES*8-1:0] wbytes,
  input  logic [SEC_BYTES-1:0]   wmask,
  input  logic [SECTOR_BITS-1:0] rsec,
  input  logic [BYTE_AW-1:0]     rbyte,
  output logic [7:0]             rdata
);
  localparam int NSEC = 1 << SECTOR_BITS;

  logic [7:0] mem_q [NSEC][SEC_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSEC; s++)
        for (int b = 0; b < SEC_BYTES; b++)
          mem_q[s][b] <= 8'hFF;
    end else if (erase_en) begin
      for (int b = 0; b < SEC_BYTES; b++)
        mem_q[wsec][b] <= 8'hFF;
    end else if (prog_en) begin
      for (int b = 0; b < SEC_BYTES; b++)
        if (wmask[b]) mem_q[wsec][b] <= wbytes[b*8 +: 8];
    end
  end

  assign rdata = mem_q[rsec][rbyte];
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int SECTOR_BITS = 2,
  parameter int LOAD_TO     = 15000,
  parameter int PROG_CYC    = 1000000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SECTOR_BITS+7:0]   addr,
  input  logic [7:0]               din,
  input  logic                     cs_n,
  input  logic                     rd_n,
  input  logic                     wr_n,
  output logic [7:0]               dout,
  output logic                     dout_en,
  output logic                     busy
);
  logic                   rst_m_n, rst_s_n;
  logic                   wr_act, wr_start, wr_end, rd_act, rd_end;
  logic                   commit, clr_buf, erase_en, prog_en, tog;
  logic [BYTE_AW-1:0]     cm_byte;
  logic [7:0]             cm_data, status, arr_rd;
  logic [SECTOR_BITS-1:0] wsec;
  logic [SEC_BYTES*8-1:0] buf_bytes;
  logic [SEC_BYTES-1:0]   buf_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_s_n <= rst_m_n;
    end
  end

  slp_strobe u_strobe (
    .clk(clk), .rst_n(rst_s_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .wr_act(wr_act), .wr_start(wr_start), .wr_end(wr_end),
    .rd_act(rd_act), .rd_end(rd_end)
  );

  slp_seq #(.SECTOR_BITS(SECTOR_BITS), .LOAD_TO(LOAD_TO), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .wr_act(wr_act), .wr_start(wr_start),
    .wr_end(wr_end), .rd_end(rd_end), .in_sec(addr[SECTOR_BITS+7:8]),
    .in_byte(addr[7:0]), .din(din), .commit(commit), .cm_byte(cm_byte),
    .cm_data(cm_data), .clr_buf(clr_buf), .erase_en(erase_en),
    .prog_en(prog_en), .sec(wsec), .busy(busy), .tog(tog), .status(status)
  );

  slp_buffer u_buf (
    .clk(clk), .rst_n(rst_s_n), .clr(clr_buf), .wr_en(commit),
    .wr_idx(cm_byte), .wr_data(cm_data), .bytes_o(buf_bytes), .mask_o(buf_mask)
  );

  slp_array #(.SECTOR_BITS(SECTOR_BITS)) u_arr (
    .clk(clk), .rst_n(rst_s_n), .erase_en(erase_en), .prog_en(prog_en),
    .wsec(wsec), .wbytes(buf_bytes), .wmask(buf_mask),
    .rsec(addr[SECTOR_BITS+7:8]), .rbyte(addr[7:0]), .rdata(arr_rd)
  );

  assign dout_en = rd_act;
  assign dout    = !rd_act ? 8'h00 : (busy ? status : arr_rd);
endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk (
  input logic clk,
  input logic rst_s_n,
  input logic cs_n,
  input logic rd_n,
  input logic wr_n,
  input logic busy,
  input logic commit,
  input logic erase_en,
  input logic prog_en,
  input logic rd_end,
  input logic tog
);
  // R5: a cycle always opens with its erase step
  a_r5_erase_first: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(busy) |-> erase_en);

  // R5: the write step happens only inside a running cycle
  a_r5_prog_in_cycle: assert property (@(posedge clk) disable iff (!rst_s_n)
    prog_en |-> ($past(busy) && busy && !erase_en));

  // R10: nothing is staged while a cycle runs
  a_r10_no_commit_busy: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy |-> !commit);

  // R9: a staged byte follows a clock with a legal strobe on the pins
  a_r9_commit_legal: assert property (@(posedge clk) disable iff (!rst_s_n)
    commit |-> ($past(rd_n) && !$past(wr_n) && !$past(cs_n)));

  // R7: status bit 6 inverts after each finished read in a cycle
  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && $past(busy) && $past(rd_end)) |-> (tog != $past(tog)));
endmodule

bind slp_ctrl slp_ctrl_chk u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .busy(busy), .commit(commit), .erase_en(erase_en), .prog_en(prog_en),
  .rd_end(rd_end), .tog(tog)
);

// File: tb/slp_ctrl_tb.sv
module slp_ctrl_tb;
  localparam int SB  = 2;
  localparam int LTO = 16;
  localparam int PC  = 40;
  localparam int AW  = SB + 8;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [7:0]    d;
  } vec_t;

  // sector 1, loaded out of order; the last entry is the final byte loaded
  localparam vec_t VEC [8] = '{
    '{a: 10'h1F0, d: 8'h3C}, '{a: 10'h105, d: 8'h81},
    '{a: 10'h100, d: 8'h00}, '{a: 10'h1FF, d: 8'h7E},
    '{a: 10'h140, d: 8'hC3}, '{a: 10'h101, d: 8'h5A},
    '{a: 10'h180, d: 8'h0F}, '{a: 10'h122, d: 8'hA5}
  };

  logic          clk, rst_n;
  logic [AW-1:0] addr;
  logic [7:0]    din, dout;
  logic          cs_n, rd_n, wr_n, dout_en, busy;

  int n_chk = 0, n_fail = 0, cyc = 0, t_rise = 0, t_fall = 0;
  logic bprev = 1'b0;
  logic done  = 1'b0;
  logic [7:0] rv;
  logic       re;

  slp_ctrl #(.SECTOR_BITS(SB), .LOAD_TO(LTO), .PROG_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (busy && !bprev) t_rise = cyc;
    if (!busy && bprev) t_fall = cyc;
    bprev = busy;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    addr = a; rd_n = 1'b0;
    #1;
    rv = dout; re = dout_en;
    @(negedge clk);
    rd_n = 1'b1;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4 * (PC + LTO) && busy; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; din = '0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R2: reset state and plain reads
    chk("R1 busy after reset", busy, 0);
    chk("R2 no drive while deselected", dout_en, 0);
    cs_n = 1'b0;
    rd(10'h000); chk("R1 erased byte", rv, 8'hFF); chk("R2 drive on read", re, 1);
    rd(10'h3FF); chk("R1 erased top byte", rv, 8'hFF);
    @(negedge clk); addr = 10'h000; #1;
    chk("R2 no drive with rd_n high", dout_en, 0);

    // R5/R6/R7: table of loads into sector 1, gaps varied below the window
    for (int i = 0; i < 8; i++) begin
      load(VEC[i].a, VEC[i].d);
      if (i == 3) load(10'h205, 8'h11); // R8 foreign sector, ignored
      if (i < 7) repeat (i) @(negedge clk);
    end
    wait (busy === 1'b1);
    @(negedge clk);
    rd(10'h122); chk("R6 first poll status", rv, 8'h25);
    rd(10'h122); chk("R7 second poll status", rv, 8'h65);
    rd(10'h000); chk("R7 third poll status", rv, 8'h25);
    wait_idle();
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i].a); chk("R5 loaded byte", rv, {24'h0, VEC[i].d});
    end
    rd(10'h122); chk("R7 true data after cycle", rv, 8'hA5);
    rd(10'h1AA); chk("R5 unloaded byte FF", rv, 8'hFF);
    rd(10'h205); chk("R8 foreign byte untouched", rv, 8'hFF);
    rd(10'h0F0); chk("R11 other sector untouched", rv, 8'hFF);

    // R9: strobes with rd_n low or cs_n high do nothing
    @(negedge clk); addr = 10'h300; din = 8'h55; rd_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk); rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b0;
    repeat (2) @(negedge clk); wr_n = 1'b1; cs_n = 1'b0;
    repeat (LTO + 4) @(negedge clk);
    chk("R9 no cycle from inhibited strobe", busy, 0);
    rd(10'h300); chk("R9 no write from inhibited strobe", rv, 8'hFF);

    // R3: address from first strobe clock, data from last
    @(negedge clk); addr = 10'h310; din = 8'h12; wr_n = 1'b0;
    @(negedge clk); addr = 10'h311; din = 8'h34;
    @(negedge clk); wr_n = 1'b1;
    wait (busy === 1'b1);
    @(negedge clk);
    load(10'h312, 8'h77); // R10 ignored while busy
    wait_idle();
    chk("R5 busy length", t_fall - t_rise, PC);
    rd(10'h310); chk("R3 address first clock data last clock", rv, 8'h34);
    rd(10'h311); chk("R3 later address not used", rv, 8'hFF);
    rd(10'h312); chk("R10 load during cycle ignored", rv, 8'hFF);
    rd(10'h122); chk("R11 sector 1 kept", rv, 8'hA5);

    // R4: strobe on the timeout edge wins
    load(10'h200, 8'h01);
    repeat (LTO - 1) @(negedge clk);
    load(10'h201, 8'h02);
    repeat (LTO) @(negedge clk);
    chk("R4 busy low one edge before timeout", busy, 0);
    @(negedge clk);
    chk("R4 busy at timeout edge", busy, 1);
    wait_idle();
    rd(10'h200); chk("R4 first byte", rv, 8'h01);
    rd(10'h201); chk("R4 boundary byte accepted", rv, 8'h02);

    // R4: one clock too late starts the cycle and drops the byte
    load(10'h220, 8'h03);
    repeat (LTO) @(negedge clk);
    load(10'h221, 8'h04);
    wait_idle();
    rd(10'h220); chk("R4 byte before gap", rv, 8'h03);
    rd(10'h221); chk("R4 late byte dropped", rv, 8'hFF);
    rd(10'h200); chk("R5 reprogram erases sector", rv, 8'hFF);

    finish_run();
  end
endmodule